// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block is a small direct-mapped private cache placed between one processor and a shared broadcast bus. Every processor store is written through to memory, so memory always holds the newest value. Coherence with the other caches on the bus comes only from watching their transactions. A remote write that lands on a line held here either drops that line or patches the line's data in place. A static mode input picks between the two.

The processor raises a request and holds its address, write flag and write data steady until the one-cycle acknowledge. The controller owns one bus-master port for its own reads and write-throughs. Arbitration happens outside the block and appears as a grant input. A snoop input shows the transactions of every other agent on the bus. A word address is split into a line index (the low log2(LINES) bits) and a tag (the remaining upper bits). Each line holds one data word.

Top module: `wt_snoop_cache`

## Requirements
- R1: Reset marks every line invalid. Out of reset, `cpu_ack`, `cpu_stall` and `bus_req` are low, and the first load to any address is a miss.
- R2: A load miss raises `bus_req` with `bus_we`=0 and `bus_addr`=`cpu_addr`. After the grant it drops the request and waits for `bus_rvalid`. It then fills the line (valid, tag, `bus_rdata`) and acknowledges in the next cycle with `cpu_rdata`=`bus_rdata`. It never acknowledges before the data arrives.
- R3: A load hit raises no bus request. It acknowledges in the cycle after the request is taken, with the cached word. `cpu_ack` is high for one cycle only.
- R4: Every store raises `bus_req` with `bus_we`=1, `bus_addr`=`cpu_addr` and `bus_wdata`=`cpu_wdata`, and acknowledges in the cycle after the grant. If the line hits when the grant arrives, its data becomes the stored word, so a later load returns that word without a bus read.
- R5: A store that misses does not allocate a line. A later load of that address is a miss.
- R6: With `mode_update`=0, a snooped write (`snp_we`=1) whose address hits a valid line clears that line's valid bit.
- R7: With `mode_update`=1, a snooped write that hits a valid line replaces its data with `snp_data` and leaves it valid. A later load hits and returns the new word.
- R8: Snooped reads, and snooped writes whose tag does not match the valid line at their index, change no line.
- R9: When a snoop and a processor access meet the same line in one cycle, the snoop takes effect first and the access is judged on the result. In mode 0 such a load misses. In mode 1 it hits and returns `snp_data`.
- R10: `cpu_stall` is high whenever a request is held and not yet acknowledged, including the whole of the block's own bus transaction.
- R11: While `bus_req` waits for a grant, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged. Only one transaction is outstanding, so stores reach the bus in processor order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_update | input | 1 | Remote-write policy: 0 invalidate, 1 update |
| cpu_req | input | 1 | Processor request, held until acknowledge |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | Request pending and not complete |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | Bus transaction is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_gnt | input | 1 | Grant from the external arbiter |
| bus_rvalid | input | 1 | Read response valid |
| bus_rdata | input | DATA_W | Read response data |
| snp_valid | input | 1 | A remote transaction is on the bus |
| snp_we | input | 1 | Remote transaction is a write |
| snp_addr | input | ADDR_W | Remote transaction address |
| snp_data | input | DATA_W | Remote write data |

## Verification
Some properties are checked on every cycle:
- the bus request holds its fields steady until granted;
- the processor stays stalled during the block's own bus traffic;
- acknowledges are single pulses that follow a write grant or a read response;
- a snooped hit in invalidate mode clears the valid bit;
- snooped reads, and any snoop in update mode, leave the valid bits alone.

Only the bench scenarios can show that returned data is coherent with memory after mixed local and remote traffic. They also show that a store miss does not allocate, and that a snoop in the same cycle as a load turns that load into a miss or a hit with the snooped word. Hits and misses are observed by counting the block's bus reads.

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_update,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ack,
  output logic              cpu_stall,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RDW, S_WR, S_DONE} st_t;
  st_t st;

  logic [LINES-1:0]  line_valid;
  logic [TAG_W-1:0]  line_tag  [LINES];
  logic [DATA_W-1:0] line_data [LINES];

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  logic snp_hit, snp_same, eff_valid, cpu_hit, fill_now, wr_commit;
  logic [DATA_W-1:0] eff_data;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  assign snp_hit   = snp_valid & snp_we & line_valid[snp_idx] & (line_tag[snp_idx] == snp_tag);
  assign snp_same  = snp_hit & (snp_idx == cpu_idx);
  assign eff_valid = line_valid[cpu_idx] & ~(snp_same & ~mode_update);
  assign eff_data  = (snp_same & mode_update) ? snp_data : line_data[cpu_idx];
  assign cpu_hit   = eff_valid & (line_tag[cpu_idx] == cpu_tag);
  assign fill_now  = (st == S_RDW) & bus_rvalid;
  assign wr_commit = (st == S_WR) & bus_gnt;

  assign bus_req   = (st == S_RD) | (st == S_WR);
  assign bus_we    = (st == S_WR);
  assign bus_addr  = cpu_addr;
  assign bus_wdata = cpu_wdata;
  assign cpu_ack   = (st == S_DONE);
  assign cpu_stall = cpu_req & ~cpu_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cpu_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          if (cpu_we) st <= S_WR;
          else if (cpu_hit) begin
            cpu_rdata <= eff_data;
            st        <= S_DONE;
          end else st <= S_RD;
        end
        S_RD:  if (bus_gnt) st <= S_RDW;
        S_RDW: if (bus_rvalid) begin
          cpu_rdata <= bus_rdata;
          st        <= S_DONE;
        end
        S_WR:  if (bus_gnt) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_valid <= '0;
    else begin
      if (snp_hit && !mode_update) line_valid[snp_idx] <= 1'b0;
      if (fill_now) line_valid[cpu_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (snp_hit && mode_update) line_data[snp_idx] <= snp_data;
    if (fill_now) begin
      line_data[cpu_idx] <= bus_rdata;
      line_tag[cpu_idx]  <= cpu_tag;
    end
    if (wr_commit && cpu_hit) line_data[cpu_idx] <= cpu_wdata;
  end
endmodule

module wt_snoop_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_update,
  input logic              cpu_ack,
  input logic              cpu_stall,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_gnt,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              snp_valid,
  input logic              snp_we,
  input logic [IDX_W-1:0]  snp_idx,
  input logic              snp_hit,
  input logic              fill_now,
  input logic [LINES-1:0]  line_valid
);
  // R10
  stall_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> cpu_stall);
  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));
  // R4
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_gnt |=> cpu_ack);
  // R2
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_gnt |=> !cpu_ack && !bus_req);
  // R2
  rd_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_now |=> cpu_ack && (cpu_rdata == $past(bus_rdata)));
  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
  // R6
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_update && snp_hit && !fill_now |=> !line_valid[$past(snp_idx)]);
  // R7
  upd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_update && snp_valid && !fill_now |=> line_valid == $past(line_valid));
  // R8
  snp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_we && !fill_now |=> line_valid == $past(line_valid));
endmodule

bind wt_snoop_cache wt_snoop_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_update(mode_update),
  .cpu_ack(cpu_ack), .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
  .snp_valid(snp_valid), .snp_we(snp_we), .snp_idx(snp_idx), .snp_hit(snp_hit),
  .fill_now(fill_now), .line_valid(line_valid)
);

// File: tb/wt_snoop_cache_tb.sv
`timescale 1ns/1ps
module wt_snoop_cache_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int LINES  = 8;
  localparam int IDX_W  = 3;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 0, rst_n = 0, mode_update = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] cpu_rdata;
  logic cpu_ack, cpu_stall, bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic bus_gnt = 0, bus_rvalid = 0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic snp_valid = 0, snp_we = 0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [DATA_W-1:0] snp_data = '0;

  wt_snoop_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_update(mode_update),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_stall(cpu_stall),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr), .snp_data(snp_data));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] mem [MEMSZ];
  logic [DATA_W-1:0] exp_mem [MEMSZ];
  logic sh_v [LINES];
  logic [ADDR_W-IDX_W-1:0] sh_t [LINES];
  int rd_cnt = 0, rd_grants = 0, wr_grants = 0;
  logic [ADDR_W-1:0] rd_a = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus and arbiter model, driven away from the active edge
  always @(negedge clk) begin
    bus_gnt = 0;
    bus_rvalid = 0;
    if (!rst_n) rd_cnt = 0;
    else if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        bus_rvalid = 1;
        bus_rdata = mem[rd_a];
      end
    end else if (bus_req && $urandom_range(2) == 0) begin
      bus_gnt = 1;
      if (bus_we) begin
        mem[bus_addr] = bus_wdata;
        wr_grants++;
      end else begin
        rd_grants++;
        rd_a = bus_addr;
        rd_cnt = 1 + $urandom_range(2);
      end
    end
  end

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction
  function automatic logic [ADDR_W-IDX_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  task automatic model_remote(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    if (we) begin
      exp_mem[a] = d;
      mem[a] = d;
      if (sh_v[idx_of(a)] && sh_t[idx_of(a)] == tag_of(a) && !mode_update)
        sh_v[idx_of(a)] = 0;
    end
  endtask

  task automatic remote(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    model_remote(we, a, d);
    snp_valid = 1; snp_we = we; snp_addr = a; snp_data = d;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic access(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        input bit sv, input logic [ADDR_W-1:0] sa, input logic [DATA_W-1:0] sd,
                        input string req);
    int rc0;
    bit pred_hit, stall_bad;
    @(negedge clk);
    rc0 = rd_grants;
    if (sv) model_remote(1'b1, sa, sd);
    pred_hit = sh_v[idx_of(a)] && sh_t[idx_of(a)] == tag_of(a);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    snp_valid = sv; snp_we = 1; snp_addr = sa; snp_data = sd;
    stall_bad = 0;
    forever begin
      @(negedge clk);
      snp_valid = 0;
      if (cpu_ack) break;
      if (!cpu_stall) stall_bad = 1;
    end
    cpu_req = 0;
    chk(!stall_bad, "R10", "stall while pending", stall_bad, 0);
    if (we) begin
      exp_mem[a] = wd;
      chk(mem[a] == wd, req, "write-through value", mem[a], wd);
      chk(rd_grants == rc0, req, "store made bus read", rd_grants - rc0, 0);
    end else begin
      chk(cpu_rdata == exp_mem[a], req, "load data", cpu_rdata, exp_mem[a]);
      chk((rd_grants != rc0) == !pred_hit, req, "miss (bus read) count",
          rd_grants - rc0, pred_hit ? 0 : 1);
      if (!pred_hit) begin
        sh_v[idx_of(a)] = 1;
        sh_t[idx_of(a)] = tag_of(a);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i] = DATA_W'(i * 131 + 7);
      exp_mem[i] = mem[i];
    end
    for (int i = 0; i < LINES; i++) begin sh_v[i] = 0; sh_t[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!bus_req, "R1", "bus_req after reset", bus_req, 0);
    chk(!cpu_ack, "R1", "cpu_ack after reset", cpu_ack, 0);
    chk(!cpu_stall, "R1", "cpu_stall after reset", cpu_stall, 0);

    mode_update = 0;
    access(0, 8'h05, 0, 0, 0, 0, "R1");            // first load misses
    access(0, 8'h05, 0, 0, 0, 0, "R3");            // hit
    access(1, 8'h05, 16'hBEEF, 0, 0, 0, "R4");     // store hit
    access(0, 8'h05, 0, 0, 0, 0, "R4");            // returns stored word, no bus
    access(1, 8'h09, 16'h1234, 0, 0, 0, "R5");     // store miss
    access(0, 8'h09, 0, 0, 0, 0, "R5");            // still misses
    remote(1, 8'h05, 16'h5A5A);                    // R6 invalidate
    access(0, 8'h05, 0, 0, 0, 0, "R6");
    remote(0, 8'h05, 16'h0000);                    // R8 snooped read
    remote(1, 8'h0D, 16'h7777);                    // R8 same index, other tag
    access(0, 8'h05, 0, 0, 0, 0, "R8");
    mode_update = 1;
    remote(1, 8'h05, 16'hC0DE);                    // R7 update
    access(0, 8'h05, 0, 0, 0, 0, "R7");
    access(0, 8'h05, 0, 1, 8'h05, 16'hD00D, "R9"); // same cycle, update: hit with snoop word
    mode_update = 0;
    access(0, 8'h05, 0, 1, 8'h05, 16'hF00F, "R9"); // same cycle, invalidate: miss

    for (int n = 0; n < 400; n++) begin
      int op;
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      if (n % 100 == 0) begin @(negedge clk); mode_update = ~mode_update; end
      op = $urandom_range(10);
      a = ADDR_W'($urandom_range(23));
      d = DATA_W'($urandom);
      if (op <= 4) access(0, a, 0, 0, 0, 0, "R2/R3");
      else if (op <= 6) access(1, a, d, 0, 0, 0, "R4/R5");
      else if (op <= 8) remote(1, a, d);
      else if (op == 9) remote(0, a, d);
      else access(0, a, 0, 1, ADDR_W'($urandom_range(23)), d, "R9");
    end

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule